// File: doc/BRIEF.md
# Flash Command and Lock Sequencer

This block is the command front end of an embedded flash controller. Software writes a 32-bit command word that carries a protection key, an opcode and an argument. The block checks the key, checks that it is idle, and checks the target against a set of per-region write-protect bits. Only then does it start the operation. The flash array is not modelled. Each accepted operation occupies a busy counter for a parameterised number of cycles, and its effect on the non-volatile state takes hold when that counter expires.

The non-volatile state consists of three parts:
- one protect bit per group of 64 pages (16 groups over 1024 pages);
- three general-purpose option bits: bit 0 enables brownout detection, bit 1 enables brownout reset, and bit 2 selects boot from flash instead of ROM;
- a security bit.

A long press on the external erase pin restores the defaults. The press is debounced with a slow-clock enable. It clears the protect and option bits and arms the next full erase, which is then the only way to clear the security bit.

Three sticky flags report the outcome of commands: ready, lock error and programming error. Reading status clears all three. The interrupt is the OR of the flags, each gated by its own enable bit.

Top module: `fcmd_seq`

## Requirements
- R1: A command write whose bits [31:24] differ from 0xA5 is refused. It sets the programming-error flag (status bit 2), starts nothing and changes no state.
- R2: A command written while busy is refused. It sets the programming-error flag, the running operation continues unchanged, and the refused command has no effect.
- R3: An accepted command raises busy in the cycle after the write. Busy stays high for exactly its duration: program (opcode 0x1) 30 cycles, erase-and-program (0x3) 60, full erase (0x8) 150, and the option, protect and security commands 4. The ready flag (status bit 0) sets in the same cycle that busy falls.
- R4: Program and erase-and-program take their page from bits [17:8]; the page's region is page/64. If that region's protect bit is set, the command sets the lock-error flag (status bit 1) and starts nothing. A full erase with any protect bit set is refused the same way.
- R5: Set-protect (0x2) sets, and clear-protect (0x4) clears, the protect bit of the region that holds the page in bits [17:8]. The change is visible when busy falls.
- R6: Set-option (0xB) and clear-option (0xD) act on option bit index [9:8]. Index 3 sets the programming-error flag and is refused. The boot_flash output follows option bit 2.
- R7: Set-security (0xF) sets the security bit. A full erase clears it only if an erase-pin event has occurred since the last such clear.
- R8: The erase pin clears all protect and option bits and arms security clearing once it has been seen high on 22 consecutive slow ticks. A press released after 21 ticks or fewer has no effect.
- R9: A status read clears all three flags in the next cycle.
- R10: irq is high exactly when some status flag is set and its bit in irq_en is set.
- R11: A correctly keyed write with any opcode other than those listed sets the programming-error flag and starts nothing.
- R12: Program, erase-and-program and full erase pulse arr_start for one cycle with busy's rise. arr_op then reads 1, 2 or 3 respectively, and arr_page holds the argument page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command word: key [31:24], argument [17:8], opcode [3:0] |
| stat_re | input | 1 | Status read strobe, clears the flags |
| irq_en | input | 3 | Interrupt enable per status flag |
| erase_pin | input | 1 | External erase request, asynchronous |
| slow_tick | input | 1 | One-cycle slow-clock enable used for debouncing |
| busy | output | 1 | Operation in progress |
| status | output | 3 | {programming error, lock error, ready} |
| irq | output | 1 | Interrupt request |
| lock_bits | output | 16 | Per-region protect bits |
| gpnvm | output | 3 | General-purpose option bits |
| boot_flash | output | 1 | Boot source select, high for flash |
| secure | output | 1 | Security bit |
| arr_start | output | 1 | Array operation start pulse |
| arr_op | output | 2 | Array operation kind: 0 idle, 1 program, 2 erase+program, 3 full erase |
| arr_page | output | 10 | Page argument of the started operation |

## Verification
The bench targets the boundaries where a mistake is easy to make:
- A protected region is aimed at by a page whose index sits on either side of a 64-page edge. A design that computed the wrong region would start a write into protected flash, or refuse a legal one.
- An erase press ends one tick short of the threshold, and another lasts exactly the threshold. An off-by-one debouncer would wipe the option bits on a glitch, or miss a real press.
- A full erase runs with the security bit set, both before and after an erase-pin event. A design that cleared security on every full erase would open the flash without a physical press.
- A command arrives during a long full erase. A design that restarted the counter would report ready at the wrong time, or apply the refused command.

Randomly keyed and unkeyed commands fill the space between these cases, each checked against a bench model of the state.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    typedef enum logic [3:0] {
        OPC_PROG   = 4'h1,
        OPC_SLOCK  = 4'h2,
        OPC_EPROG  = 4'h3,
        OPC_CLOCK  = 4'h4,
        OPC_FERASE = 4'h8,
        OPC_SOPT   = 4'hB,
        OPC_COPT   = 4'hD,
        OPC_SSEC   = 4'hF
    } fcmd_opc_e;

    typedef enum logic [1:0] {
        ARR_IDLE   = 2'd0,
        ARR_PROG   = 2'd1,
        ARR_EPROG  = 2'd2,
        ARR_FERASE = 2'd3
    } fcmd_arr_e;

    localparam int FLAG_READY = 0;
    localparam int FLAG_LOCKE = 1;
    localparam int FLAG_PROGE = 2;
    localparam int FLAG_N     = 3;

endpackage

// File: rtl/fcmd_erase_filter.sv
module fcmd_erase_filter #(
    parameter int TICKS = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic erase_pin,
    input  logic slow_tick,
    output logic trig
);
    localparam int CW = $clog2(TICKS + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          fired;
        logic          trig;
    } filt_t;

    filt_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], erase_pin};
        s_d.trig = 1'b0;
        if (!s_q.sync[1]) begin
            s_d.cnt   = '0;
            s_d.fired = 1'b0;
        end else if (slow_tick && !s_q.fired) begin
            if (s_q.cnt == CW'(TICKS - 1)) begin
                s_d.trig  = 1'b1;
                s_d.fired = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign trig = s_q.trig;

    // R8: one press produces a single event
    assert_single_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.trig |=> !s_q.trig);

    // R8: an event needs the pin seen high
    assert_event_needs_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.trig) |-> $past(s_q.sync[1]));

endmodule

// File: rtl/fcmd_busy_timer.sv
module fcmd_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             busy,
    output logic             expire
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    assign expire = s_q.busy && (s_q.cnt == CNT_W'(1));

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = load;
        end else if (s_q.busy) begin
            if (expire) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;

    // R2: no operation is launched over a running one
    assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !s_q.busy);

    // R3: the count ends the busy period
    assert_expire_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !s_q.busy);

    // R3: a started operation shows busy on the next cycle
    assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> s_q.busy);

endmodule

// File: rtl/fcmd_check.sv
module fcmd_check
    import fcmd_pkg::*;
#(
    parameter int          PAGE_W   = 10,
    parameter int          REG_W    = 4,
    parameter int          REGIONS  = 16,
    parameter int          OPT_BITS = 3,
    parameter int          CNT_W    = 8,
    parameter logic [7:0]  KEY      = 8'hA5,
    parameter int          T_PROG   = 30,
    parameter int          T_EPROG  = 60,
    parameter int          T_FERASE = 150,
    parameter int          T_NVM    = 4
) (
    input  logic               we,
    input  logic [31:0]        wdata,
    input  logic               busy,
    input  logic [REGIONS-1:0] lock,
    output logic               accept,
    output logic               lock_err,
    output logic               prog_err,
    output logic [CNT_W-1:0]   dur,
    output fcmd_arr_e          arr,
    output logic [3:0]         opc,
    output logic [PAGE_W-1:0]  arg
);
    localparam int IDX_W = $clog2(OPT_BITS + 1);

    logic [REG_W-1:0] region;
    logic [IDX_W-1:0] opt_idx;
    logic             unused_bits;

    assign opc         = wdata[3:0];
    assign arg         = wdata[8 +: PAGE_W];
    assign region      = arg[PAGE_W-1 -: REG_W];
    assign opt_idx     = arg[IDX_W-1:0];
    assign unused_bits = ^{wdata[23:8+PAGE_W], wdata[7:4]};

    always_comb begin
        accept   = 1'b0;
        lock_err = 1'b0;
        prog_err = 1'b0;
        dur      = CNT_W'(T_NVM);
        arr      = ARR_IDLE;
        if (we) begin
            if (wdata[31:24] != KEY || busy) begin
                prog_err = 1'b1;
            end else begin
                case (opc)
                    OPC_PROG: begin
                        if (lock[region]) lock_err = 1'b1;
                        else begin
                            accept = 1'b1;
                            dur    = CNT_W'(T_PROG);
                            arr    = ARR_PROG;
                        end
                    end
                    OPC_EPROG: begin
                        if (lock[region]) lock_err = 1'b1;
                        else begin
                            accept = 1'b1;
                            dur    = CNT_W'(T_EPROG);
                            arr    = ARR_EPROG;
                        end
                    end
                    OPC_FERASE: begin
                        if (|lock) lock_err = 1'b1;
                        else begin
                            accept = 1'b1;
                            dur    = CNT_W'(T_FERASE);
                            arr    = ARR_FERASE;
                        end
                    end
                    OPC_SLOCK, OPC_CLOCK, OPC_SSEC: accept = 1'b1;
                    OPC_SOPT, OPC_COPT: begin
                        if (opt_idx >= IDX_W'(OPT_BITS)) prog_err = 1'b1;
                        else accept = 1'b1;
                    end
                    default: prog_err = 1'b1;
                endcase
            end
        end
    end

    // R1: each write gets at most one verdict
    always_comb begin
        assert_one_verdict_R1: assert ($onehot0({accept, lock_err, prog_err}));
    end

endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
    import fcmd_pkg::*;
#(
    parameter int         PAGES        = 1024,
    parameter int         REGION_PAGES = 64,
    parameter int         OPT_BITS     = 3,
    parameter logic [7:0] KEY          = 8'hA5,
    parameter int         T_PROG       = 30,
    parameter int         T_EPROG      = 60,
    parameter int         T_FERASE     = 150,
    parameter int         T_NVM        = 4,
    parameter int         ERASE_TICKS  = 22
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_we,
    input  logic [31:0]                cmd_wdata,
    input  logic                       stat_re,
    input  logic [FLAG_N-1:0]          irq_en,
    input  logic                       erase_pin,
    input  logic                       slow_tick,
    output logic                       busy,
    output logic [FLAG_N-1:0]          status,
    output logic                       irq,
    output logic [PAGES/REGION_PAGES-1:0] lock_bits,
    output logic [OPT_BITS-1:0]        gpnvm,
    output logic                       boot_flash,
    output logic                       secure,
    output logic                       arr_start,
    output logic [1:0]                 arr_op,
    output logic [$clog2(PAGES)-1:0]   arr_page
);
    localparam int REGIONS = PAGES / REGION_PAGES;
    localparam int PAGE_W  = $clog2(PAGES);
    localparam int REG_W   = $clog2(REGIONS);
    localparam int IDX_W   = $clog2(OPT_BITS + 1);
    localparam int T_MAX1  = (T_PROG > T_EPROG) ? T_PROG : T_EPROG;
    localparam int T_MAX2  = (T_MAX1 > T_FERASE) ? T_MAX1 : T_FERASE;
    localparam int T_MAX   = (T_MAX2 > T_NVM) ? T_MAX2 : T_NVM;
    localparam int CNT_W   = $clog2(T_MAX + 1);

    typedef struct packed {
        logic [REGIONS-1:0]  lock;
        logic [OPT_BITS-1:0] opt;
        logic                sec;
        logic                armed;
        logic [FLAG_N-1:0]   flags;
        logic [3:0]          pend_opc;
        logic [PAGE_W-1:0]   pend_arg;
        logic                arr_start;
        fcmd_arr_e           arr_op;
        logic [PAGE_W-1:0]   arr_page;
    } seq_t;

    seq_t s_d, s_q;

    logic               chk_accept;
    logic               chk_lerr;
    logic               chk_perr;
    logic [CNT_W-1:0]   chk_dur;
    fcmd_arr_e          chk_arr;
    logic [3:0]         chk_opc;
    logic [PAGE_W-1:0]  chk_arg;
    logic               tmr_busy;
    logic               tmr_expire;
    logic               erase_trig;
    logic [REG_W-1:0]   pend_region;
    logic [IDX_W-1:0]   pend_idx;
    logic [FLAG_N-1:0]  new_flags;

    fcmd_check #(
        .PAGE_W   (PAGE_W),
        .REG_W    (REG_W),
        .REGIONS  (REGIONS),
        .OPT_BITS (OPT_BITS),
        .CNT_W    (CNT_W),
        .KEY      (KEY),
        .T_PROG   (T_PROG),
        .T_EPROG  (T_EPROG),
        .T_FERASE (T_FERASE),
        .T_NVM    (T_NVM)
    ) u_check (
        .we       (cmd_we),
        .wdata    (cmd_wdata),
        .busy     (tmr_busy),
        .lock     (s_q.lock),
        .accept   (chk_accept),
        .lock_err (chk_lerr),
        .prog_err (chk_perr),
        .dur      (chk_dur),
        .arr      (chk_arr),
        .opc      (chk_opc),
        .arg      (chk_arg)
    );

    fcmd_busy_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (chk_accept),
        .load   (chk_dur),
        .busy   (tmr_busy),
        .expire (tmr_expire)
    );

    fcmd_erase_filter #(
        .TICKS (ERASE_TICKS)
    ) u_erase (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_pin (erase_pin),
        .slow_tick (slow_tick),
        .trig      (erase_trig)
    );

    assign pend_region = s_q.pend_arg[PAGE_W-1 -: REG_W];
    assign pend_idx    = s_q.pend_arg[IDX_W-1:0];

    always_comb begin
        new_flags             = '0;
        new_flags[FLAG_READY] = tmr_expire;
        new_flags[FLAG_LOCKE] = chk_lerr;
        new_flags[FLAG_PROGE] = chk_perr;
    end

    always_comb begin
        s_d           = s_q;
        s_d.arr_start = 1'b0;
        s_d.arr_op    = ARR_IDLE;

        if (chk_accept) begin
            s_d.pend_opc  = chk_opc;
            s_d.pend_arg  = chk_arg;
            s_d.arr_start = (chk_arr != ARR_IDLE);
            s_d.arr_op    = chk_arr;
            s_d.arr_page  = chk_arg;
        end

        if (tmr_expire) begin
            case (s_q.pend_opc)
                OPC_SLOCK:  s_d.lock[pend_region] = 1'b1;
                OPC_CLOCK:  s_d.lock[pend_region] = 1'b0;
                OPC_SOPT:   s_d.opt[pend_idx] = 1'b1;
                OPC_COPT:   s_d.opt[pend_idx] = 1'b0;
                OPC_SSEC:   s_d.sec = 1'b1;
                OPC_FERASE: begin
                    if (s_q.armed) begin
                        s_d.sec   = 1'b0;
                        s_d.armed = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        if (erase_trig) begin
            s_d.lock  = '0;
            s_d.opt   = '0;
            s_d.armed = 1'b1;
        end

        s_d.flags = (stat_re ? '0 : s_q.flags) | new_flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = tmr_busy;
    assign status     = s_q.flags;
    assign irq        = |(s_q.flags & irq_en);
    assign lock_bits  = s_q.lock;
    assign gpnvm      = s_q.opt;
    assign boot_flash = s_q.opt[OPT_BITS-1];
    assign secure     = s_q.sec;
    assign arr_start  = s_q.arr_start;
    assign arr_op     = s_q.arr_op;
    assign arr_page   = s_q.arr_page;

    // R4: the array is never started in a protected region
    assert_start_unprotected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.arr_start && s_q.arr_op != ARR_FERASE) |-> !s_q.lock[s_q.arr_page[PAGE_W-1 -: REG_W]]);

    // R3: ready only appears as an operation ends
    assert_ready_with_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flags[FLAG_READY]) |-> $fell(tmr_busy));

    // R7: security only drops at the end of an operation
    assert_secure_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.sec) |-> $fell(tmr_busy));

    // R10: no interrupt without a pending flag
    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|s_q.flags));

    // R12: start pulse coincides with busy rising
    assert_start_with_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.arr_start |-> ($rose(tmr_busy) && s_q.arr_op != ARR_IDLE));

endmodule

// File: tb/fcmd_seq_bench.sv
module fcmd_seq_bench;

    localparam logic [7:0] KEY = 8'hA5;
    localparam int TP = 30, TE = 60, TF = 150, TN = 4, ETK = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        stat_re = 1'b0;
    logic [2:0]  irq_en = '0;
    logic        erase_pin = 1'b0;
    logic        slow_tick = 1'b0;
    logic        busy, irq, boot_flash, secure, arr_start;
    logic [2:0]  status, gpnvm;
    logic [15:0] lock_bits;
    logic [1:0]  arr_op;
    logic [9:0]  arr_page;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_lock = '0;
    logic [2:0]  m_opt = '0;
    logic        m_sec = 1'b0;
    logic        m_armed = 1'b0;

    always #5 clk = ~clk;

    fcmd_seq #(
        .KEY(KEY), .T_PROG(TP), .T_EPROG(TE), .T_FERASE(TF), .T_NVM(TN), .ERASE_TICKS(ETK)
    ) u_fcmd_seq (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .stat_re(stat_re), .irq_en(irq_en), .erase_pin(erase_pin), .slow_tick(slow_tick),
        .busy(busy), .status(status), .irq(irq), .lock_bits(lock_bits), .gpnvm(gpnvm),
        .boot_flash(boot_flash), .secure(secure), .arr_start(arr_start),
        .arr_op(arr_op), .arr_page(arr_page)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(logic [7:0] key, int arg, logic [3:0] opc);
        return {key, 6'd0, 10'(arg), 4'd0, opc};
    endfunction

    // 0 accept, 1 lock error, 2 programming error
    function automatic int verdict(logic [31:0] w);
        logic [9:0] pg;
        pg = w[17:8];
        if (w[31:24] != KEY) return 2;
        case (w[3:0])
            4'h1, 4'h3: return m_lock[pg / 64] ? 1 : 0;
            4'h8:       return (m_lock != 0) ? 1 : 0;
            4'h2, 4'h4, 4'hF: return 0;
            4'hB, 4'hD: return (pg[1:0] == 2'd3) ? 2 : 0;
            default:    return 2;
        endcase
    endfunction

    function automatic int duration(logic [3:0] opc);
        case (opc)
            4'h1: return TP;
            4'h3: return TE;
            4'h8: return TF;
            default: return TN;
        endcase
    endfunction

    function automatic int arr_kind(logic [3:0] opc);
        case (opc)
            4'h1: return 1;
            4'h3: return 2;
            4'h8: return 3;
            default: return 0;
        endcase
    endfunction

    task automatic model_apply(logic [31:0] w);
        logic [9:0] pg;
        pg = w[17:8];
        case (w[3:0])
            4'h2: m_lock[pg / 64] = 1'b1;
            4'h4: m_lock[pg / 64] = 1'b0;
            4'hB: m_opt[pg[1:0]] = 1'b1;
            4'hD: m_opt[pg[1:0]] = 1'b0;
            4'hF: m_sec = 1'b1;
            4'h8: if (m_armed) begin m_sec = 1'b0; m_armed = 1'b0; end
            default: ;
        endcase
    endtask

    task automatic clear_status();
        @(negedge clk) stat_re = 1'b1;
        @(negedge clk) stat_re = 1'b0;
    endtask

    task automatic check_state(string tag);
        chk({tag, " R5 lock_bits"}, int'(lock_bits), int'(m_lock));
        chk({tag, " R6 gpnvm"}, int'(gpnvm), int'(m_opt));
        chk({tag, " R6 boot_flash"}, int'(boot_flash), int'(m_opt[2]));
        chk({tag, " R7 secure"}, int'(secure), int'(m_sec));
    endtask

    task automatic run_cmd(logic [31:0] w, string tag);
        int v, d, n;
        clear_status();
        v = verdict(w);
        d = duration(w[3:0]);
        @(negedge clk) begin cmd_we = 1'b1; cmd_wdata = w; end
        @(negedge clk) cmd_we = 1'b0;
        if (v == 0) begin
            chk({tag, " R3 busy rises"}, int'(busy), 1);
            chk({tag, " R12 arr_start"}, int'(arr_start), arr_kind(w[3:0]) != 0 ? 1 : 0);
            chk({tag, " R12 arr_op"}, int'(arr_op), arr_kind(w[3:0]));
            if (arr_kind(w[3:0]) != 0)
                chk({tag, " R12 arr_page"}, int'(arr_page), int'(w[17:8]));
            n = 0;
            while (busy && n < 400) begin n++; @(negedge clk); end
            chk({tag, " R3 duration"}, n, d);
            chk({tag, " R3 ready flag"}, int'(status), 3'b001);
            model_apply(w);
        end else begin
            chk({tag, " R1 R11 not busy"}, int'(busy), 0);
            chk({tag, " R4 no arr_start"}, int'(arr_start), 0);
            chk({tag, " R4 R1 error flag"}, int'(status), v == 1 ? 3'b010 : 3'b100);
        end
        check_state(tag);
    endtask

    task automatic press(int ticks);
        @(negedge clk) erase_pin = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < ticks; i++) begin
            slow_tick = 1'b1;
            @(negedge clk) slow_tick = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        erase_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] w;
        int unsigned seed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset busy R3", int'(busy), 0);
        chk("reset status R9", int'(status), 0);
        chk("reset irq R10", int'(irq), 0);
        check_state("reset");

        // R5 / R4 region boundaries
        run_cmd(mk(KEY, 5 * 64 + 3, 4'h2), "set protect region 5");
        run_cmd(mk(KEY, 5 * 64, 4'h1), "R4 program first page of region 5");
        run_cmd(mk(KEY, 6 * 64 - 1, 4'h3), "R4 erase-program last page of region 5");
        run_cmd(mk(KEY, 5 * 64 - 1, 4'h1), "R4 program page just below region 5");
        run_cmd(mk(KEY, 6 * 64, 4'h3), "R4 erase-program page just above region 5");
        run_cmd(mk(KEY, 0, 4'h8), "R4 full erase with protect set");

        // R10 interrupt gating on the lock error flag still pending
        irq_en = 3'b010; #1;
        chk("R10 irq enabled lock err", int'(irq), 1);
        irq_en = 3'b101; #1;
        chk("R10 irq masked lock err", int'(irq), 0);
        irq_en = 3'b000;
        // R9 clear on read
        clear_status();
        chk("R9 status cleared", int'(status), 0);

        run_cmd(mk(KEY, 5 * 64 + 40, 4'h4), "R5 clear protect region 5");
        run_cmd(mk(KEY, 5 * 64, 4'h1), "R4 program region 5 after clear");

        // R1 / R11 / R6 refusals
        run_cmd(mk(8'h5A, 10, 4'h1), "R1 wrong key");
        run_cmd(mk(8'hA4, 1, 4'h2), "R1 near key");
        run_cmd(mk(KEY, 10, 4'h6), "R11 unknown opcode");
        run_cmd(mk(KEY, 3, 4'hB), "R6 option index 3");
        run_cmd(mk(KEY, 2, 4'hB), "R6 set boot option");
        run_cmd(mk(KEY, 0, 4'hB), "R6 set option 0");

        // R2 command during busy
        clear_status();
        @(negedge clk) begin cmd_we = 1'b1; cmd_wdata = mk(KEY, 0, 4'h8); end
        @(negedge clk) cmd_we = 1'b0;
        repeat (20) @(negedge clk);
        @(negedge clk) begin cmd_we = 1'b1; cmd_wdata = mk(KEY, 64, 4'h2); end
        @(negedge clk) cmd_we = 1'b0;
        chk("R2 perr while busy", int'(status), 3'b100);
        chk("R2 still busy", int'(busy), 1);
        chk("R2 no restart arr_start", int'(arr_start), 0);
        begin
            int n = 22;
            while (busy && n < 400) begin n++; @(negedge clk); end
            chk("R2 original duration kept", n, TF);
        end
        chk("R2 ready and perr", int'(status), 3'b101);
        model_apply(mk(KEY, 0, 4'h8));
        check_state("R2 refused protect not applied");

        // R7 / R8 security and erase pin
        run_cmd(mk(KEY, 0, 4'hF), "R7 set security");
        run_cmd(mk(KEY, 0, 4'h8), "R7 full erase without pin event");
        run_cmd(mk(KEY, 200, 4'h2), "R8 protect before press");
        press(ETK - 1);
        check_state("R8 short press ignored");
        press(ETK);
        m_lock = '0; m_opt = '0; m_armed = 1'b1;
        check_state("R8 long press clears");
        run_cmd(mk(KEY, 0, 4'h8), "R7 full erase after pin event");
        run_cmd(mk(KEY, 0, 4'hF), "R7 set security again");
        run_cmd(mk(KEY, 0, 4'h8), "R7 second full erase keeps security");

        // random commands
        seed = 32'd1234;
        void'($urandom(seed));
        for (int i = 0; i < 80; i++) begin
            logic [3:0] opcs [9];
            logic [7:0] key;
            opcs = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h8, 4'hB, 4'hD, 4'hF, 4'h7};
            key = ($urandom % 8 == 0) ? 8'(KEY ^ 8'($urandom % 255 + 1)) : KEY;
            w = mk(key, int'($urandom % 1024), opcs[$urandom % 9]);
            run_cmd(w, "random R1 R3 R4 R5 R6 R12");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule